// File: doc/BRIEF.md
# Posted Write Buffer Retire Controller

This block holds one posted column write for a banked DRAM device model. A write command addressed to this device loads its data unit, byte enables, bank and column into a single buffer entry. Nothing is written to the sense-amp array at that point. The entry drains into the array later, during a column-command slot whose type and target allow it.

Slots that allow a drain are a no-op aimed at any device, a write aimed at any device, and a read aimed at another device. A read aimed at this device never drains the buffer, so that the read path does not collide with the write path inside the device.

When a same-device read targets the bank and column of the still-pending write, the block raises a hazard flag. This makes the stale-data window visible to the surrounding model. The array itself, row activation and packet reception are outside the block.

Top module: `wbuf_retire_ctrl`

## Requirements
- R1: A command with `cmd_valid`=1, `cmd_op`=2 (write) and `cmd_self`=1 captures `cmd_bank`, `cmd_col`, `cmd_data` and `cmd_mask` into the buffer, and `pending` is 1 from the next clock edge.
- R2: The write that fills an empty buffer produces no retire strobe: `ret_en` stays 0 on the following edge.
- R3: With `pending`=1, a valid no-op (`cmd_op`=0, any `cmd_self`), a valid write (any `cmd_self`) or a valid read (`cmd_op`=1) with `cmd_self`=0 gives a one-cycle `ret_en` on the next edge. The `ret_bank`, `ret_col`, `ret_data` and `ret_mask` outputs then carry the buffered entry, and `pending` drops unless R6 applies.
- R4: A valid read with `cmd_self`=1 never produces `ret_en`, and `pending` keeps its value.
- R5: `ret_en` is raised only when the buffer held an entry; a drain-allowed slot with an empty buffer gives no strobe.
- R6: A same-device write arriving while `pending`=1 retires the old entry (outputs show the old fields) and captures the new one on the same edge, so `pending` stays 1.
- R7: `rd_hazard` is 1 for one cycle after a valid same-device read whose bank and column both equal the pending entry's. It is 0 for a mismatching address, for a read aimed at another device, and for an empty buffer.
- R8: `cmd_op`=3 is reserved, and a cycle with `cmd_valid`=0 is idle; neither captures, retires nor raises the hazard.
- R9: After reset `pending`, `ret_en` and `rd_hazard` are 0.
- R10: The column field is 6 bits (64 columns per bank) and the bank field 5 bits, with extremes 63 and 31 kept exactly. `ret_mask` bit i enables data bits 8i+7..8i, with 1 meaning write the byte; the mask is passed to the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A column command is present this cycle |
| cmd_op | input | 2 | 0 no-op, 1 read, 2 write, 3 reserved |
| cmd_self | input | 1 | Command is addressed to this device |
| cmd_bank | input | 5 | Bank field of the command |
| cmd_col | input | 6 | Column field of the command |
| cmd_data | input | 128 | Write data unit |
| cmd_mask | input | 16 | Byte enables of the write, 1 = write byte |
| ret_en | output | 1 | Retire strobe to the sense-amp array |
| ret_bank | output | 5 | Bank of the retiring entry |
| ret_col | output | 6 | Column of the retiring entry |
| ret_data | output | 128 | Data of the retiring entry |
| ret_mask | output | 16 | Byte enables of the retiring entry |
| rd_hazard | output | 1 | Same-device read hit a pending write |
| pending | output | 1 | Buffer holds an entry not yet retired |

## Verification
Every result of this block is registered once. A command presented in one cycle shows its retire strobe, retire fields, hazard flag and new `pending` value right after the clock edge that samples it, with no further delay. The bench drives each command on the falling edge and computes the expected outputs from its own model of the entry. It compares all outputs 2 ns after the following rising edge, so each check lands on the single cycle where that command's effect is due.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int DATA_W = 128;
    localparam int MASK_W = DATA_W / 8;
    localparam int COLS   = 64;
    localparam int COL_W  = $clog2(COLS);
    localparam int BANK_W = 5;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_RSV = 2'd3
    } col_cmd_e;

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
    } slot_t;

    typedef struct packed {
        logic              ret_en;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
        logic              hazard;
    } drain_out_t;
endpackage

// File: rtl/wbuf_slot_policy.sv
module wbuf_slot_policy
    import wbuf_pkg::*;
(
    input  logic     cmd_valid,
    input  col_cmd_e cmd_op,
    input  logic     cmd_self,
    input  logic     slot_valid,
    input  logic     addr_match,
    output logic     retire,
    output logic     capture,
    output logic     hazard
);
    logic is_rd;
    logic is_wr;
    logic is_nop;
    logic slot_ok;

    always_comb begin
        is_rd   = cmd_valid && (cmd_op == CMD_RD);
        is_wr   = cmd_valid && (cmd_op == CMD_WR);
        is_nop  = cmd_valid && (cmd_op == CMD_NOP);
        // a read to this device holds the internal data path
        slot_ok = is_nop || is_wr || (is_rd && !cmd_self);
        retire  = slot_valid && slot_ok;
        capture = is_wr && cmd_self;
        hazard  = is_rd && cmd_self && slot_valid && addr_match;
    end
endmodule

// File: rtl/wbuf_slot.sv
module wbuf_slot
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              retire,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MASK_W-1:0] in_mask,
    output slot_t             slot_o
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (retire) begin
            slot_d.valid = 1'b0;
        end
        if (capture) begin
            slot_d.valid = 1'b1;
            slot_d.bank  = in_bank;
            slot_d.col   = in_col;
            slot_d.data  = in_data;
            slot_d.mask  = in_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_o = slot_q;

    assert_capture_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> slot_q.valid);
    assert_retire_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !capture) |=> !slot_q.valid);
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !capture) |=> $stable(slot_q));
endmodule

// File: rtl/wbuf_retire_ctrl.sv
module wbuf_retire_ctrl
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_self,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [MASK_W-1:0] cmd_mask,
    output logic              ret_en,
    output logic [BANK_W-1:0] ret_bank,
    output logic [COL_W-1:0]  ret_col,
    output logic [DATA_W-1:0] ret_data,
    output logic [MASK_W-1:0] ret_mask,
    output logic              rd_hazard,
    output logic              pending
);
    slot_t      slot;
    logic       retire;
    logic       capture;
    logic       hazard;
    logic       addr_match;
    col_cmd_e   op;
    drain_out_t out_d, out_q;

    assign op         = col_cmd_e'(cmd_op);
    assign addr_match = (slot.bank == cmd_bank) && (slot.col == cmd_col);

    wbuf_slot_policy u_policy (
        .cmd_valid  (cmd_valid),
        .cmd_op     (op),
        .cmd_self   (cmd_self),
        .slot_valid (slot.valid),
        .addr_match (addr_match),
        .retire     (retire),
        .capture    (capture),
        .hazard     (hazard)
    );

    wbuf_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .retire  (retire),
        .in_bank (cmd_bank),
        .in_col  (cmd_col),
        .in_data (cmd_data),
        .in_mask (cmd_mask),
        .slot_o  (slot)
    );

    always_comb begin
        out_d        = out_q;
        out_d.ret_en = retire;
        out_d.hazard = hazard;
        if (retire) begin
            // the old entry leaves before any same-edge capture replaces it
            out_d.bank = slot.bank;
            out_d.col  = slot.col;
            out_d.data = slot.data;
            out_d.mask = slot.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ret_en    = out_q.ret_en;
    assign ret_bank  = out_q.bank;
    assign ret_col   = out_q.col;
    assign ret_data  = out_q.data;
    assign ret_mask  = out_q.mask;
    assign rd_hazard = out_q.hazard;
    assign pending   = slot.valid;

    assert_no_self_read_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && cmd_self) |=> !ret_en);
    assert_strobe_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> $past(pending));
    assert_pending_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> (pending == $past(cmd_valid && cmd_op == 2'd2 && cmd_self)));
    assert_hazard_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hazard |-> $past(cmd_valid && cmd_op == 2'd1 && cmd_self && pending));
    assert_hazard_excl_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hazard && ret_en));
    assert_reserved_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> (!ret_en && !rd_hazard && $stable(pending)));
endmodule

// File: tb/tb_wbuf_retire_ctrl.sv
module tb_wbuf_retire_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic         cmd_self = 1'b0;
    logic [4:0]   cmd_bank = '0;
    logic [5:0]   cmd_col = '0;
    logic [127:0] cmd_data = '0;
    logic [15:0]  cmd_mask = '0;
    logic         ret_en, rd_hazard, pending;
    logic [4:0]   ret_bank;
    logic [5:0]   ret_col;
    logic [127:0] ret_data;
    logic [15:0]  ret_mask;

    int total = 0;
    int bad = 0;

    // reference entry
    bit           m_valid = 0;
    logic [4:0]   m_bank = '0;
    logic [5:0]   m_col = '0;
    logic [127:0] m_data = '0;
    logic [15:0]  m_mask = '0;

    always #10 clk = ~clk;

    wbuf_retire_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_self(cmd_self), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_data(cmd_data), .cmd_mask(cmd_mask), .ret_en(ret_en),
        .ret_bank(ret_bank), .ret_col(ret_col), .ret_data(ret_data),
        .ret_mask(ret_mask), .rd_hazard(rd_hazard), .pending(pending)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] op, input bit self,
                        input logic [4:0] bank, input logic [5:0] col,
                        input logic [127:0] data, input logic [15:0] mask,
                        input string req);
        bit e_ret, e_hz, e_cap, e_pend;
        logic [4:0] e_bank; logic [5:0] e_col;
        logic [127:0] e_data; logic [15:0] e_mask;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_self = self; cmd_bank = bank;
        cmd_col = col; cmd_data = data; cmd_mask = mask;
        e_ret  = v && m_valid && (op == 2'd0 || op == 2'd2 || (op == 2'd1 && !self));
        e_cap  = v && op == 2'd2 && self;
        e_hz   = v && op == 2'd1 && self && m_valid && bank == m_bank && col == m_col;
        e_bank = m_bank; e_col = m_col; e_data = m_data; e_mask = m_mask;
        e_pend = e_cap ? 1'b1 : (e_ret ? 1'b0 : m_valid);
        if (e_cap) begin
            m_bank = bank; m_col = col; m_data = data; m_mask = mask;
        end
        m_valid = e_pend;
        @(posedge clk); #2;
        chk(ret_en == e_ret, {req, " ret_en"}, 128'(ret_en), 128'(e_ret));
        chk(rd_hazard == e_hz, {req, " rd_hazard"}, 128'(rd_hazard), 128'(e_hz));
        chk(pending == e_pend, {req, " pending"}, 128'(pending), 128'(e_pend));
        if (e_ret && ret_en) begin
            chk(ret_bank == e_bank, {req, " ret_bank"}, 128'(ret_bank), 128'(e_bank));
            chk(ret_col == e_col, {req, " ret_col"}, 128'(ret_col), 128'(e_col));
            chk(ret_data == e_data, {req, " ret_data"}, ret_data, e_data);
            chk(ret_mask == e_mask, {req, " ret_mask"}, 128'(ret_mask), 128'(e_mask));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!pending && !ret_en && !rd_hazard, "R9 reset", 128'({pending, ret_en, rd_hazard}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        // empty buffer, drain-allowed slots
        step(1, 2'd0, 1, 5'd1, 6'd1, 128'h0, 16'h0, "R5");
        step(1, 2'd2, 0, 5'd1, 6'd1, 128'h0, 16'h0, "R5");
        // first capture
        step(1, 2'd2, 1, 5'd3, 6'd10, 128'hA5A5_0001, 16'hFFFF, "R1 R2");
        step(1, 2'd1, 1, 5'd3, 6'd10, 128'h0, 16'h0, "R7 R4");
        step(1, 2'd1, 1, 5'd3, 6'd11, 128'h0, 16'h0, "R7 R4");
        step(1, 2'd1, 1, 5'd4, 6'd10, 128'h0, 16'h0, "R7 R4");
        step(1, 2'd1, 0, 5'd3, 6'd10, 128'h0, 16'h0, "R3 R7");
        // extreme address, partial mask
        step(1, 2'd2, 1, 5'd31, 6'd63, {4{32'hDEAD_BEEF}}, 16'h00F0, "R10");
        step(1, 2'd3, 1, 5'd31, 6'd63, 128'h0, 16'h0, "R8");
        step(0, 2'd0, 0, 5'd0, 6'd0, 128'h0, 16'h0, "R8");
        step(1, 2'd2, 1, 5'd0, 6'd0, 128'h1234, 16'h8001, "R6 R10");
        step(1, 2'd2, 0, 5'd9, 6'd9, 128'h0, 16'h0, "R3");
        step(1, 2'd2, 1, 5'd7, 6'd33, 128'h77, 16'h0F0F, "R1");
        step(1, 2'd0, 0, 5'd0, 6'd0, 128'h0, 16'h0, "R3");
        step(1, 2'd1, 1, 5'd7, 6'd33, 128'h0, 16'h0, "R7");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], r[4], {3'b0, r[6:5]}, {4'b0, r[8:7]},
                 {$urandom, $urandom, $urandom, $urandom}, r[31:16], "R3 R6 R7");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule